// File: doc/BRIEF.md
# Multi-Cycle 32-bit Datapath

This block is the datapath half of a small multi-cycle processor. It executes a reduced integer instruction set: register-register add, subtract, AND, OR and signed set-less-than, word load, word store, branch-on-equal and an absolute jump. A separate sequencer, outside this block, drives one set of control lines each clock cycle. It reads back the opcode and function fields and the ALU zero flag so it can choose its next state.

A single memory port carries both instruction fetches and data accesses. A single ALU does every addition and comparison. Values pass from one cycle to the next through five holding registers: the instruction register, two operand latches, the ALU result latch and the memory data latch. Each holding register, and the program counter, changes only when its own enable is asserted.

The branch target is computed during decode for every instruction, before the opcode is known. A branch then only needs to compare its operands and select the latched target.

Top module: `mcd_core`

## Requirements
- R1: A synchronous active-low reset clears the program counter and all holding registers to zero. After reset, the memory address with the PC selected is 0, and the opcode and function outputs are 0.
- R2: The program counter, instruction register, operand latches, ALU result latch and memory data latch keep their values in any cycle where their enables are low. The PC also keeps its value when the conditional enable is high and the zero flag is low.
- R3: Fetch step: `addr_sel`=0, `ir_we`=1, `alu_a_sel`=0, `alu_b_sel`=1 (constant 4), `alu_op`=0 and `pc_src`=0 with `pc_we`=1. The memory address equals the PC, the instruction register loads `mem_rdata`, and the PC becomes PC+4. `opcode` shows IR[31:26] and `funct` shows IR[5:0].
- R4: Decode step with `ab_we`=1: the operand latches load register[IR[25:21]] and register[IR[20:16]]. With `alu_b_sel`=3, `alu_a_sel`=0 and `alu_out_we`=1, the ALU result latch loads PC + (sign-extended IR[15:0] << 2).
- R5: `alu_op`=0 adds and `alu_op`=1 subtracts. `alu_op`=2 decodes `funct` as follows: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than, which gives 1 or 0. `alu_b_sel`=2 selects the sign-extended IR[15:0], and `alu_a_sel`=1 selects operand latch A.
- R6: `mem_addr` is the PC when `addr_sel`=0 and the ALU result latch when `addr_sel`=1. For loads and stores this address is A + sign-extended immediate.
- R7: With `mdr_we`=1 the memory data latch captures `mem_rdata`. A later cycle with `reg_we`=1, `reg_dst`=0 and `mem_to_reg`=1 writes it to register[IR[20:16]].
- R8: `mem_wdata` carries operand latch B, and `mem_we` follows the `mem_wr` control.
- R9: With `reg_we`=1, `reg_dst`=1 and `mem_to_reg`=0, the ALU result latch is written to register[IR[15:11]].
- R10: Branch step: `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1, `pc_cond_we`=1, `pc_src`=1. `alu_zero` is high exactly when A equals B, and then the PC loads the ALU result latch. Otherwise the PC is unchanged.
- R11: With `pc_src`=2 and `pc_we`=1, the PC loads {PC[31:28], IR[25:0], 2'b00}.
- R12: Register 0 always reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_we | input | 1 | Unconditional PC write enable |
| pc_cond_we | input | 1 | PC write enable qualified by the zero flag |
| ir_we | input | 1 | Instruction register enable |
| ab_we | input | 1 | Operand latch enable |
| alu_out_we | input | 1 | ALU result latch enable |
| mdr_we | input | 1 | Memory data latch enable |
| reg_we | input | 1 | Register file write enable |
| mem_wr | input | 1 | Memory write request |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| reg_dst | input | 1 | Destination select: 0 IR[20:16], 1 IR[15:11] |
| mem_to_reg | input | 1 | Write-back select: 0 ALU result latch, 1 memory data latch |
| alu_a_sel | input | 1 | ALU A select: 0 PC, 1 operand latch A |
| alu_b_sel | input | 2 | ALU B select: 0 B, 1 four, 2 immediate, 3 immediate<<2 |
| alu_op | input | 2 | 0 add, 1 subtract, 2 decode funct |
| pc_src | input | 2 | PC source: 0 ALU, 1 ALU result latch, 2 jump target |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| opcode | output | 6 | IR[31:26] for the sequencer |
| funct | output | 6 | IR[5:0] for the sequencer |
| alu_zero | output | 1 | ALU result equals zero |

## Verification
The assertions assume that the sequencer only writes memory while the address select points at the ALU result latch. They also assume that a fetch advance always uses the PC, the constant four and an add together. The bench plays the sequencer. It drives only the documented step patterns for fetch, decode, execute, memory and write-back, plus deliberate idle steps with every enable low. The bench also models memory and places each instruction and load word at the address the model predicts just before it is used. Register contents are observed only through stores. This covers a sweep of every function code over every pair of eight boundary operand values, with the expected results computed arithmetically.

// File: rtl/mcd_pkg.sv
// Package: shared encodings for the multi-cycle datapath.
// Assumes a 32-bit instruction word with 6-bit opcode and function fields.
package mcd_pkg;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_FOUR = 2'd1,
        BSRC_IMM  = 2'd2,
        BSRC_OFS  = 2'd3
    } bsrc_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2,
        AOP_RSVD  = 2'd3
    } aluop_e;

    typedef enum logic [1:0] {
        PCS_ALU  = 2'd0,
        PCS_LAT  = 2'd1,
        PCS_JUMP = 2'd2,
        PCS_RSVD = 2'd3
    } pcsrc_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_SLT = 3'd4
    } alufn_e;

    localparam logic [5:0] FUNCT_ADD = 6'h20;
    localparam logic [5:0] FUNCT_SUB = 6'h22;
    localparam logic [5:0] FUNCT_AND = 6'h24;
    localparam logic [5:0] FUNCT_OR  = 6'h25;
    localparam logic [5:0] FUNCT_SLT = 6'h2A;

endpackage

// File: rtl/mcd_regfile.sv
// Module: two-read, one-write register file.
// Entry 0 is hardwired to zero. Reads are combinational; the write lands at the clock edge.
// Assumes REG_COUNT is a power of two no larger than 32.
module mcd_regfile #(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 32,
    localparam int RA_W     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RA_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RA_W-1:0]   raddr_a,
    input  logic [RA_W-1:0]   raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs [REG_COUNT];

    // Entry 0 is a constant; the others are storage.
    assign regs[0] = '0;

    genvar gi;
    generate
        for (gi = 1; gi < REG_COUNT; gi++) begin : g_entry
            // Each entry clears on reset and loads when addressed by a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[gi] <= '0;
                else if (we && waddr == RA_W'(gi))
                    regs[gi] <= wdata;
            end
        end
    endgenerate

    // Combinational read ports.
    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R9 / R7: a write to a nonzero entry is visible on the next cycle.
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));

    // R12: entry 0 never holds anything but zero, whatever is written.
    a_r12_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (rdata_a == '0 || raddr_a != '0));

endmodule

// File: rtl/mcd_aluctl.sv
// Module: turns the sequencer's ALU request and the instruction function field into an ALU function.
// Assumes unknown function codes may safely default to add.
module mcd_aluctl
    import mcd_pkg::*;
(
    input  aluop_e      op,
    input  logic [5:0]  funct,
    output alufn_e      fn
);

    // Select a fixed operation or decode the function field.
    always_comb begin
        unique case (op)
            AOP_ADD: fn = FN_ADD;
            AOP_SUB: fn = FN_SUB;
            AOP_FUNCT: begin
                case (funct)
                    FUNCT_ADD: fn = FN_ADD;
                    FUNCT_SUB: fn = FN_SUB;
                    FUNCT_AND: fn = FN_AND;
                    FUNCT_OR:  fn = FN_OR;
                    FUNCT_SLT: fn = FN_SLT;
                    default:   fn = FN_ADD;
                endcase
            end
            default: fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/mcd_alu.sv
// Module: single shared integer ALU with a zero flag.
// Assumes signed two's-complement compare for set-less-than.
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  alufn_e            fn,
    output logic [DATA_W-1:0] result,
    output logic              zero
);

    // Compute the requested operation.
    always_comb begin
        case (fn)
            FN_ADD:  result = op_a + op_b;
            FN_SUB:  result = op_a - op_b;
            FN_AND:  result = op_a & op_b;
            FN_OR:   result = op_a | op_b;
            FN_SLT:  result = {{(DATA_W-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
            default: result = op_a + op_b;
        endcase
    end

    // Flag an all-zero result, which the branch compare relies on.
    assign zero = (result == '0);

    // R5: set-less-than yields only 0 or 1.
    always_comb begin
        if (fn == FN_SLT)
            a_r5_slt_bool: assert (result[DATA_W-1:1] == '0);
    end

endmodule

// File: rtl/mcd_core.sv
// Module: multi-cycle datapath top.
// Holds the PC and the instruction, operand, result and memory data latches.
// Shares one ALU and one memory port across cycles.
// Assumes an external sequencer supplies one control word per cycle, and that
// DATA_W is 32 because the instruction fields are fixed.
module mcd_core
    import mcd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_COUNT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_we,
    input  logic              pc_cond_we,
    input  logic              ir_we,
    input  logic              ab_we,
    input  logic              alu_out_we,
    input  logic              mdr_we,
    input  logic              reg_we,
    input  logic              mem_wr,
    input  logic              addr_sel,
    input  logic              reg_dst,
    input  logic              mem_to_reg,
    input  logic              alu_a_sel,
    input  logic [1:0]        alu_b_sel,
    input  logic [1:0]        alu_op,
    input  logic [1:0]        pc_src,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [5:0]        opcode,
    output logic [5:0]        funct,
    output logic              alu_zero
);

    localparam int RA_W  = $clog2(REG_COUNT);
    localparam int IMM_W = 16;
    localparam int JT_W  = 26;

    logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, alu_out_q, mdr_q;
    logic [DATA_W-1:0] rf_a, rf_b, rf_wdata, imm_ext, imm_ofs, jump_tgt;
    logic [DATA_W-1:0] alu_in_a, alu_in_b, alu_res, pc_next;
    logic [RA_W-1:0]   rs_idx, rt_idx, rd_idx, wr_idx;
    logic              pc_load;
    bsrc_e             b_sel_e;
    aluop_e            op_e;
    pcsrc_e            pcs_e;
    alufn_e            fn;

    assign b_sel_e = bsrc_e'(alu_b_sel);
    assign op_e    = aluop_e'(alu_op);
    assign pcs_e   = pcsrc_e'(pc_src);

    // Instruction field extraction.
    assign rs_idx   = ir_q[21 +: RA_W];
    assign rt_idx   = ir_q[16 +: RA_W];
    assign rd_idx   = ir_q[11 +: RA_W];
    assign imm_ext  = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign imm_ofs  = {imm_ext[DATA_W-3:0], 2'b00};
    assign jump_tgt = {pc_q[DATA_W-1:JT_W+2], ir_q[JT_W-1:0], 2'b00};
    assign opcode   = ir_q[31:26];
    assign funct    = ir_q[5:0];

    // Register file write-back selection.
    assign wr_idx   = reg_dst ? rd_idx : rt_idx;
    assign rf_wdata = mem_to_reg ? mdr_q : alu_out_q;

    mcd_regfile #(
        .DATA_W    (DATA_W),
        .REG_COUNT (REG_COUNT)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (wr_idx),
        .wdata   (rf_wdata),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    // ALU operand A: program counter or latched rs value.
    assign alu_in_a = alu_a_sel ? a_q : pc_q;

    // ALU operand B: latched rt, constant four, immediate or word offset.
    always_comb begin
        case (b_sel_e)
            BSRC_REG:  alu_in_b = b_q;
            BSRC_FOUR: alu_in_b = DATA_W'(4);
            BSRC_IMM:  alu_in_b = imm_ext;
            default:   alu_in_b = imm_ofs;
        endcase
    end

    mcd_aluctl u_aluctl (
        .op    (op_e),
        .funct (funct),
        .fn    (fn)
    );

    mcd_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_a   (alu_in_a),
        .op_b   (alu_in_b),
        .fn     (fn),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Next PC source selection.
    always_comb begin
        case (pcs_e)
            PCS_ALU:  pc_next = alu_res;
            PCS_LAT:  pc_next = alu_out_q;
            PCS_JUMP: pc_next = jump_tgt;
            default:  pc_next = alu_res;
        endcase
    end

    assign pc_load = pc_we || (pc_cond_we && alu_zero);

    // Program counter: cleared on reset, loaded when enabled or when a branch is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (pc_load)
            pc_q <= pc_next;
    end

    // Instruction and memory data latches share the read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            mdr_q <= '0;
        end else begin
            if (ir_we)  ir_q  <= mem_rdata;
            if (mdr_we) mdr_q <= mem_rdata;
        end
    end

    // Operand latches capture the register file outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (ab_we) begin
            a_q <= rf_a;
            b_q <= rf_b;
        end
    end

    // ALU result latch carries addresses, targets and results to the next step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alu_out_q <= '0;
        else if (alu_out_we)
            alu_out_q <= alu_res;
    end

    // Memory port.
    assign mem_addr  = addr_sel ? alu_out_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = mem_wr;

    // R3: a fetch advance adds four to the PC.
    a_r3_fetch_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pcs_e == PCS_ALU && !alu_a_sel && b_sel_e == BSRC_FOUR && op_e == AOP_ADD)
        |=> (pc_q == $past(pc_q) + DATA_W'(4)));

    // R2: the PC holds when no load condition is present.
    a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && !(pc_cond_we && alu_zero)) |=> $stable(pc_q));

    // R2: the instruction register holds without its enable.
    a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_we |=> $stable(ir_q));

    // R6 / R8: memory writes only target the computed data address.
    a_r8_store_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> addr_sel);

    // R10: a taken compare loads the latched target.
    a_r10_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_cond_we && !pc_we && pcs_e == PCS_LAT && alu_zero) |=> (pc_q == $past(alu_out_q)));

    // R11: a jump keeps the upper PC bits and produces a word-aligned target.
    a_r11_jump_form: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pcs_e == PCS_JUMP)
        |=> (pc_q[1:0] == 2'b00 && pc_q[DATA_W-1:JT_W+2] == $past(pc_q[DATA_W-1:JT_W+2])));

endmodule

// File: tb/mcd_core_tb.sv
// Bench: acts as sequencer and memory, and checks register contents through stores.
module mcd_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pc_we, pc_cond_we, ir_we, ab_we, alu_out_we, mdr_we, reg_we, mem_wr;
    logic        addr_sel, reg_dst, mem_to_reg, alu_a_sel;
    logic [1:0]  alu_b_sel, alu_op, pc_src;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_we, alu_zero;
    logic [5:0]  opcode, funct;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] rm  [32];
    logic [31:0] pc_m;
    logic [31:0] vals [8];
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:2]];

    mcd_core u_dut (
        .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_cond_we(pc_cond_we), .ir_we(ir_we),
        .ab_we(ab_we), .alu_out_we(alu_out_we), .mdr_we(mdr_we), .reg_we(reg_we),
        .mem_wr(mem_wr), .addr_sel(addr_sel), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {pc_we, pc_cond_we, ir_we, ab_we, alu_out_we, mdr_we, reg_we, mem_wr} = '0;
        {addr_sel, reg_dst, mem_to_reg, alu_a_sel} = '0;
        alu_b_sel = 2'd0; alu_op = 2'd0; pc_src = 2'd0;
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h20:   return a + b;
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            default: return {31'd0, ($signed(a) < $signed(b))};
        endcase
    endfunction

    // Fetch and decode; tag names the requirement that predicted the PC.
    task automatic fetch_decode(input logic [31:0] instr, input string tag);
        @(negedge clk); idle();
        mem[pc_m[11:2]] = instr;
        ir_we = 1; pc_we = 1; alu_b_sel = 2'd1;
        #1 chk({tag, " fetch address"}, mem_addr, pc_m);
        pc_m = pc_m + 32'd4;
        @(negedge clk); idle();
        ab_we = 1; alu_out_we = 1; alu_b_sel = 2'd3;
        #1 chk("R3 opcode/funct", {20'd0, opcode, funct}, {20'd0, instr[31:26], instr[5:0]});
    endtask

    task automatic do_lw(input int rs, input int rt, input logic [15:0] imm, input logic [31:0] data);
        logic [31:0] ea;
        fetch_decode(enc_i(6'h23, rs, rt, imm), "R3");
        ea = rm[rs] + sx(imm);
        @(negedge clk); idle();
        alu_a_sel = 1; alu_b_sel = 2'd2; alu_out_we = 1;
        @(negedge clk); idle();
        mem[ea[11:2]] = data;
        addr_sel = 1; mdr_we = 1;
        #1 chk("R6 load address", mem_addr, ea);
        @(negedge clk); idle();
        reg_we = 1; mem_to_reg = 1;
        if (rt != 0) rm[rt] = data;
    endtask

    // Store with an optional decoy step whose enables are all low.
    task automatic do_sw(input int rs, input int rt, input logic [15:0] imm, input string tag, input bit decoy);
        logic [31:0] ea;
        fetch_decode(enc_i(6'h2B, rs, rt, imm), "R3");
        ea = rm[rs] + sx(imm);
        if (decoy) begin
            @(negedge clk); idle();
            alu_a_sel = 1; alu_b_sel = 2'd1; pc_src = 2'd2; addr_sel = 1; mem_to_reg = 1;
        end
        @(negedge clk); idle();
        alu_a_sel = 1; alu_b_sel = 2'd2; alu_out_we = 1;
        @(negedge clk); idle();
        addr_sel = 1; mem_wr = 1;
        #1;
        chk("R6 store address", mem_addr, ea);
        chk("R8 store enable", {31'd0, mem_we}, 32'd1);
        chk({tag, " store data"}, mem_wdata, rm[rt]);
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
    endtask

    task automatic do_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        fetch_decode(enc_r(rs, rt, rd, fn), "R3");
        @(negedge clk); idle();
        alu_a_sel = 1; alu_op = 2'd2; alu_out_we = 1;
        @(negedge clk); idle();
        reg_we = 1; reg_dst = 1;
        if (rd != 0) rm[rd] = alu_ref(fn, rm[rs], rm[rt]);
    endtask

    task automatic do_beq(input int rs, input int rt, input logic [15:0] imm);
        logic [31:0] tgt;
        logic        eq;
        fetch_decode(enc_i(6'h04, rs, rt, imm), "R3");
        tgt = pc_m + (sx(imm) << 2);
        eq  = (rm[rs] == rm[rt]);
        @(negedge clk); idle();
        alu_a_sel = 1; alu_op = 2'd1; pc_cond_we = 1; pc_src = 2'd1;
        #1 chk("R10 zero flag", {31'd0, alu_zero}, {31'd0, eq});
        if (eq) pc_m = tgt;
    endtask

    task automatic do_j(input logic [25:0] t);
        fetch_decode({6'h02, t}, "R3");
        @(negedge clk); idle();
        pc_we = 1; pc_src = 2'd2;
        pc_m = {pc_m[31:28], t, 2'b00};
    endtask

    initial begin
        logic [5:0] fns [5];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
        vals[6] = 32'hFFFF_FFF9; vals[7] = 32'h1234_5678;
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        for (int i = 0; i < 32; i++) rm[i] = '0;
        pc_m = '0;
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset PC", mem_addr, 32'd0);
        chk("R1 reset IR fields", {20'd0, opcode, funct}, 32'd0);
        chk("R1 reset store data latch", mem_wdata, 32'd0);

        // R2: idle cycle leaves the PC in place.
        @(negedge clk); idle(); mem_to_reg = 1; alu_b_sel = 2'd1;
        fetch_decode(enc_r(0, 0, 0, 6'h20), "R2");
        @(negedge clk); idle();

        // R7: load eight boundary values and read each back through a store.
        for (int i = 0; i < 8; i++) do_lw(0, i + 1, 16'(32'h100 + 4 * i), vals[i]);
        for (int i = 0; i < 8; i++) do_sw(0, i + 1, 16'h0200, "R7", 1'b0);

        // R5 / R9: every function code over every operand pair.
        for (int f = 0; f < 5; f++)
            for (int i = 1; i <= 8; i++)
                for (int j = 1; j <= 8; j++) begin
                    do_r(i, j, 9, fns[f]);
                    do_sw(0, 9, 16'h0204, "R5 R9", 1'b0);
                end

        // R12: writes to register 0 are ignored.
        do_r(3, 2, 0, 6'h20);
        do_sw(0, 0, 16'h0208, "R12", 1'b0);
        do_lw(0, 0, 16'h0120, 32'hCAFE_F00D);
        do_sw(0, 0, 16'h020C, "R12", 1'b0);

        // R6: nonzero base with a negative offset; R2: the decoy step keeps B.
        do_lw(0, 10, 16'h0130, 32'h0000_0300);
        do_lw(10, 11, 16'hFFF4, 32'h5A5A_A5A5);
        do_sw(10, 11, 16'hFFF8, "R6", 1'b0);
        do_sw(0, 7, 16'h0210, "R2", 1'b1);

        // R4 / R10: taken forward, not taken, taken backward.
        do_beq(1, 1, 16'h0003);
        fetch_decode(enc_r(0, 0, 0, 6'h20), "R4 R10 taken");
        do_beq(2, 3, 16'h0005);
        fetch_decode(enc_r(0, 0, 0, 6'h20), "R10 not taken");
        do_beq(0, 1, 16'hFFFE);
        fetch_decode(enc_r(0, 0, 0, 6'h20), "R4 R10 backward");

        // R11: jumps.
        do_j(26'h000_0040);
        fetch_decode(enc_r(0, 0, 0, 6'h20), "R11");
        do_j(26'h000_0007);
        fetch_decode(enc_r(0, 0, 0, 6'h20), "R11");

        @(negedge clk); idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule